// File: doc/BRIEF.md
# Replay FIFO with Bookmark and Rewind

This block is a single-clock synchronous FIFO with a registered read output. Besides ordinary first-in first-out buffering, the reader can set a bookmark on its current read position and later rewind the read position to that bookmark, so that a stretch of stored words can be delivered again as many times as needed. A typical use is a link layer that keeps a frame for resending until it is acknowledged: the frame start is bookmarked, the frame is streamed out, and on a negative acknowledge the reader rewinds and streams it again.

While a bookmark is held, the storage between the bookmark and the write position is protected. The writer sees the FIFO as full once the write position is a whole depth ahead of the bookmark, so replay data is never overwritten. Dropping the bookmark input releases the protection and returns the FIFO to plain operation.

Top module: `fifo_rt`

## Requirements
- R1: While `rst_ni` is low, `empty_o` is 1, `full_o` is 0 and `rdata_o` is all zeros.
- R2: A clock edge with `wen_ni` low and `full_o` low stores `wdata_i`; after a write into an empty FIFO, `empty_o` is 0 from that edge on.
- R3: A clock edge with `ren_ni` low and `empty_o` low places the oldest unread word on `rdata_o` after that edge, in write order; with `empty_o` high the read is ignored and `rdata_o` holds its value.
- R4: With no bookmark held, `full_o` is 1 when 2**AW words are stored; a write while `full_o` is 1 is dropped.
- R5: An edge with `mark_i` high while no bookmark is held records the current read position (the next unread word, which is the word read at that same edge if a read occurs) and enters bookmark mode; keeping `mark_i` high does not move the bookmark.
- R6: An edge with `mark_i` low leaves bookmark mode and removes the write protection.
- R7: An edge with `rt_ni` low and `mark_i` high in bookmark mode moves the read position back to the bookmark; `empty_o` is 1 for the one cycle after that edge, reads are ignored at that edge, and the following reads return the words from the bookmark onward again; this can be repeated any number of times.
- R8: In bookmark mode `full_o` is 1 when the write position is 2**AW words ahead of the bookmark, regardless of reads, and writes are then dropped.
- R9: `rt_ni` low while not in bookmark mode has no effect.
- R10: A write and a read at the same edge both take effect when the flags allow them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for reads and writes |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wdata_i | input | DW | Write data |
| wen_ni | input | 1 | Write enable, active low |
| ren_ni | input | 1 | Read enable, active low |
| mark_i | input | 1 | Bookmark set and hold, active high |
| rt_ni | input | 1 | Rewind request, active low |
| rdata_o | output | DW | Registered read data |
| empty_o | output | 1 | No word available to read |
| full_o | output | 1 | No space to write |

## Verification
Plain FIFO traffic is tried as separate write bursts and read bursts, as interleaved simultaneous reads and writes, and as a fill past capacity, which separates ordering faults from flag-boundary faults. Bookmark traffic sets a mark mid-stream, reads past it while holding, then rewinds twice; comparing the replayed words against the words captured after the mark separates a rewind to the wrong place from a mark that moves while held. Filling the FIFO while the mark is held and then reading shows whether the full flag tracks the bookmark or the read position, and a rewind request with the mark low shows that it is ignored.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HELD   = 2'd1,
    ST_SETTLE = 2'd2
  } mark_st_e;
endpackage

// File: rtl/fifo_rt_ram.sv
module fifo_rt_ram #(
  parameter int DW = 20,
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl
  import fifo_rt_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wen_ni,
  input  logic          ren_ni,
  input  logic          mark_i,
  input  logic          rt_ni,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          held_o
);
  localparam logic [AW:0] FULL_LVL = {1'b1, {AW{1'b0}}};

  logic [AW:0] wr_q, rd_q, mark_q;
  logic [AW:0] used, lvl, base;
  mark_st_e    st_q, st_d;
  logic        in_mode, rewind, take_mark;

  assign held_o    = (st_q != ST_IDLE);
  assign in_mode   = held_o && mark_i;
  assign rewind    = in_mode && !rt_ni;
  assign take_mark = mark_i && !held_o;

  // write protection is measured from the bookmark while one is held
  assign base    = held_o ? mark_q : rd_q;
  assign used    = wr_q - rd_q;
  assign lvl     = wr_q - base;
  assign full_o  = (lvl == FULL_LVL);
  assign empty_o = (used == '0) || (st_q == ST_SETTLE);

  assign wr_en_o   = !wen_ni && !full_o;
  assign rd_en_o   = !ren_ni && !empty_o && !rewind;
  assign wr_addr_o = wr_q[AW-1:0];
  assign rd_addr_o = rd_q[AW-1:0];

  always_comb begin
    if (!mark_i)       st_d = ST_IDLE;
    else if (!held_o)  st_d = ST_HELD;
    else if (rewind)   st_d = ST_SETTLE;
    else               st_d = ST_HELD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      mark_q <= '0;
      st_q   <= ST_IDLE;
    end else begin
      st_q <= st_d;
      if (wr_en_o)   wr_q   <= wr_q + 1'b1;
      if (take_mark) mark_q <= rd_q;
      if (rewind)        rd_q <= mark_q;
      else if (rd_en_o)  rd_q <= rd_q + 1'b1;
    end
  end
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt #(
  parameter int DW = 20,
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          wen_ni,
  input  logic          ren_ni,
  input  logic          mark_i,
  input  logic          rt_ni,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);
  logic          wr_en, rd_en, held;
  logic [AW-1:0] wr_addr, rd_addr;

  fifo_rt_ctrl #(.AW(AW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wen_ni    (wen_ni),
    .ren_ni    (ren_ni),
    .mark_i    (mark_i),
    .rt_ni     (rt_ni),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .empty_o   (empty_o),
    .full_o    (full_o),
    .held_o    (held)
  );

  fifo_rt_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (wdata_i),
    .re_i    (rd_en),
    .raddr_i (rd_addr),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int DW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wen_ni,
  input logic          ren_ni,
  input logic          mark_i,
  input logic          rt_ni,
  input logic [DW-1:0] rdata_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          held_i
);
  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (empty_o && !full_o && rdata_o == '0));

  p_empty_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |=> $stable(rdata_o));

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && ren_ni && !held_i |=> full_o);

  p_exit_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mark_i |=> !held_i);

  p_rewind_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_i && mark_i && !rt_ni |=> empty_o);

  p_mark_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_i && mark_i && full_o |=> full_o);

  p_rt_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !held_i && !rt_ni && ren_ni && wen_ni |=> $stable(empty_o) && $stable(rdata_o));
endmodule

bind fifo_rt fifo_rt_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wen_ni  (wen_ni),
  .ren_ni  (ren_ni),
  .mark_i  (mark_i),
  .rt_ni   (rt_ni),
  .rdata_o (rdata_o),
  .empty_o (empty_o),
  .full_o  (full_o),
  .held_i  (held)
);

// File: tb/fifo_rt_tb_top.sv
module fifo_rt_tb_top;
  localparam int  DW         = 20;
  localparam int  AW         = 6;
  localparam int  DEPTH      = 1 << AW;
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          wen_n = 1'b1, ren_n = 1'b1, mark = 1'b0, rt_n = 1'b1;
  logic [DW-1:0] rdata;
  logic          empty, full;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference
  int            m_wr = 0, m_rd = 0, m_mark = 0;
  bit            m_held = 0, m_settle = 0;
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] m_dout = '0;
  logic [DW-1:0] sbq [$];

  fifo_rt #(.DW(DW), .AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wdata_i(wdata), .wen_ni(wen_n),
    .ren_ni(ren_n), .mark_i(mark), .rt_ni(rt_n),
    .rdata_o(rdata), .empty_o(empty), .full_o(full)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit m_full();
    int base = m_held ? m_mark : m_rd;
    return (m_wr - base) == DEPTH;
  endfunction

  function automatic bit m_empty();
    return (m_wr == m_rd) || m_settle;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit w, logic [DW-1:0] d, bit r, bit mk, bit rt);
    bit f, e, drt, drd, dwr;
    int rd0;
    wen_n = !w; wdata = d; ren_n = !r; mark = mk; rt_n = !rt;
    f = m_full(); e = m_empty(); rd0 = m_rd;
    drt = m_held && mk && rt;
    drd = r && !e && !drt;
    dwr = w && !f;
    if (dwr) begin m_mem[m_wr % DEPTH] = d; m_wr++; end
    if (drd) begin m_dout = m_mem[m_rd % DEPTH]; m_rd++; end
    if (mk && !m_held) m_mark = rd0;
    if (drt) m_rd = m_mark;
    m_settle = drt;
    m_held = mk;
    @(negedge clk);
    chk({cur_req, " rdata"}, 32'(rdata), 32'(m_dout));
    chk({cur_req, " empty"}, 32'(empty), 32'(m_empty()));
    chk({cur_req, " full"},  32'(full),  32'(m_full()));
  endtask

  task automatic drain(bit mk);
    while (!m_empty()) step(0, '0, 1, mk, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 rdata", 32'(rdata), 0);
    rst_n = 1'b1;

    cur_req = "R3";
    step(0, '0, 1, 0, 0);
    step(0, '0, 1, 0, 0);
    chk("R3 empty read ignored", 32'(rdata), 0);

    cur_req = "R2";
    for (int i = 0; i < 5; i++) begin
      step(1, DW'(i * 3 + 1), 0, 0, 0);
      if (i == 0) chk("R2 not empty after write", 32'(empty), 0);
    end
    cur_req = "R3";
    for (int i = 0; i < 5; i++) begin
      step(0, '0, 1, 0, 0);
      chk("R3 order", 32'(rdata), 32'(i * 3 + 1));
    end
    chk("R3 empty after drain", 32'(empty), 1);

    cur_req = "R10";
    step(1, 20'h00aa0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, DW'(20'h00ab0 + i), 1, 0, 0);
    chk("R10 concurrent read", 32'(rdata), 32'h00ab2);
    drain(0);

    cur_req = "R4";
    for (int i = 0; i < DEPTH + 6; i++) step(1, DW'(20'h10000 + i), 0, 0, 0);
    chk("R4 full", 32'(full), 1);
    for (int i = 0; i < DEPTH; i++) step(0, '0, 1, 0, 0);
    chk("R4 last kept", 32'(rdata), 32'(20'h10000 + DEPTH - 1));
    chk("R4 dropped extra", 32'(empty), 1);

    cur_req = "R9";
    for (int i = 0; i < 3; i++) step(1, DW'(20'h20000 + i), 0, 0, 0);
    step(0, '0, 1, 0, 0);
    step(0, '0, 0, 0, 1);
    chk("R9 rewind ignored empty", 32'(empty), 0);
    step(0, '0, 1, 0, 0);
    chk("R9 rewind ignored data", 32'(rdata), 32'h20001);
    drain(0);

    cur_req = "R5";
    for (int i = 0; i < 20; i++) step(1, DW'(20'h30000 + i), 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0, 0);
    step(0, '0, 0, 1, 0);
    for (int i = 0; i < 5; i++) begin
      step(0, '0, 1, 1, 0);
      sbq.push_back(rdata);
    end
    chk("R5 first after mark", 32'(sbq[0]), 32'h30003);

    cur_req = "R7";
    for (int k = 0; k < 2; k++) begin
      step(0, '0, 1, 1, 1);
      chk("R7 empty on rewind", 32'(empty), 1);
      step(0, '0, 0, 1, 0);
      chk("R7 settle done", 32'(empty), 0);
      for (int i = 0; i < 5; i++) begin
        step(0, '0, 1, 1, 0);
        chk("R7 replay", 32'(rdata), 32'(sbq[i]));
      end
    end

    cur_req = "R8";
    for (int i = 0; i < 60; i++) step(1, DW'(20'h40000 + i), 0, 1, 0);
    chk("R8 blocked at mark", 32'(full), 1);
    step(0, '0, 1, 1, 0);
    step(0, '0, 1, 1, 0);
    chk("R8 full after reads", 32'(full), 1);
    step(1, 20'hfffff, 0, 1, 0);

    cur_req = "R6";
    step(0, '0, 0, 0, 0);
    chk("R6 release", 32'(full), 0);
    step(1, 20'h50000, 0, 0, 0);
    cur_req = "R9";
    step(0, '0, 0, 0, 1);
    chk("R9 no rewind after release", 32'(empty), 0);
    cur_req = "R3";
    drain(0);
    chk("R3 last word", 32'(rdata), 32'h50000);

    finish_run();
  end
endmodule